// File: doc/BRIEF.md
# Inter-Chip IO Loopback Tester

This block exercises a 32-bit parallel link between two chips. A host fills a 512-word transmit memory through a narrow byte-wide access port. After a start command the block streams that memory onto the outgoing link bus without pause, wrapping from the last word back to the first. It waits for a programmable number of cycles, then records the returning bus, one word per cycle, into a second 512-word receive memory. The host then reads the receive memory and compares it with what it sent. Because the capture point can be moved in single-cycle steps, the host can measure the round-trip delay and the alignment of every bit of the link.

The run ends in one of three ways. It completes after 512 captured words. A stop command during capture ends the run early and keeps the words already captured. A stop command during the latency wait aborts the run and writes nothing. A single clock serves both the host access and the test traffic. Host word reads are combinational.

The sequencer has four states. IDLE is entered at reset and after an abort. LATENCY counts down the programmed wait. CAPTURE records returning words. DONE is entered on completion or on a stop during capture. The transitions are:
- IDLE or DONE to LATENCY on a start command.
- LATENCY to IDLE on a stop command.
- LATENCY to CAPTURE when the countdown reaches zero.
- CAPTURE to DONE on a stop command, or on the write of the last word.

Top module: `iolink_tester`

## Requirements
- R1: While reset is asserted and right after it, `busy` and `done` are 0 and `link_tx` is all zeros.
- R2: A host write with `host_addr` = 0x1D stores `host_wdata` into byte lane `host_lane` of transmit word `host_word`. Lane 0 is bits 7:0 and lane 3 is bits 31:24. This write is accepted at any time. `host_rdata` shows the addressed byte of the addressed word in the same cycle. Any `host_addr` other than 0x1D or 0x1E reads as 0.
- R3: A host write with `host_addr` = 0x1E stores a byte into the receive memory only while `busy` is 0. Such a write while `busy` is 1 leaves the memory unchanged.
- R4: A `cmd_start` pulse in IDLE or DONE makes `busy` 1 and `done` 0 from the next cycle on. A `cmd_start` while `busy` is 1 is ignored, and the transmit stream is not restarted.
- R5: With `latency` = L sampled at the start edge, the LATENCY state lasts L+1 cycles before CAPTURE is entered.
- R6: After the k-th clock edge following the start edge (k ≥ 1), and while `busy` is 1, `link_tx` equals transmit word (k-1) mod 512.
- R7: In CAPTURE, receive word j holds the value `link_rx` had in the j-th capture cycle. With `link_rx` wired straight to `link_tx` and latency L, receive word j equals transmit word (L+j) mod 512.
- R8: After 512 words have been captured, the block enters DONE with `done` = 1 and `busy` = 0. This happens L+513 cycles after the start edge. `done` is never 1 while `busy` is 1.
- R9: A `cmd_stop` present at a clock edge in CAPTURE writes no word at that edge, ends the run, and sets `done`. Words captured earlier are kept, and later receive words keep their old contents.
- R10: A `cmd_stop` present at a clock edge in LATENCY returns the block to IDLE with `done` = 0, and no receive word is written.
- R11: `link_tx` is all zeros whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for host access and test traffic |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Memory select: 0x1D transmit, 0x1E receive |
| host_word | input | 9 | Word index inside the selected memory |
| host_lane | input | 2 | Byte lane inside the word, 0 = bits 7:0 |
| host_wdata | input | 8 | Byte to write |
| host_we | input | 1 | Host byte write strobe |
| host_rdata | output | 8 | Addressed byte, combinational |
| cmd_start | input | 1 | Start a run |
| cmd_stop | input | 1 | Stop or abort the current run |
| latency | input | 16 | Wait in cycles before capture begins |
| link_tx | output | 32 | Outgoing link bus, registered |
| link_rx | input | 32 | Returning link bus |
| busy | output | 1 | Run in progress (LATENCY or CAPTURE) |
| done | output | 1 | Last run completed or was stopped during capture |

## Verification
A sequencer stuck in or skipping the LATENCY state shows at the ports at once. `busy` drops too early or too late, and every receive word is shifted by the same number of positions against the transmit pattern. A wrong transmit pointer corrupts `link_tx` in the first cycle it is wrong. A wrong capture pointer or write enable only shows when the host reads the receive memory after the run, as displaced words or as words that changed although the run was aborted. Wrong stop handling shows within one cycle on `busy` and `done`.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LATENCY = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } lbt_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/lbt_ram.sv
module lbt_ram
    import lbt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 512,
    parameter int NRD   = 1,
    localparam int AW    = $clog2(DEPTH),
    localparam int LANES = DW / BYTE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  byte_we,
    input  logic [AW-1:0]     byte_addr,
    input  logic [BYTE_W-1:0] byte_wdata,
    input  logic              word_we,
    input  logic [AW-1:0]     word_addr,
    input  logic [DW-1:0]     word_wdata,
    input  logic [AW-1:0]     rd_addr [NRD],
    output logic [DW-1:0]     rd_data [NRD]
);

    logic [DW-1:0] mem [DEPTH];

    logic word_hits_byte;
    assign word_hits_byte = word_we && (word_addr == byte_addr);

    always_ff @(posedge clk) begin
        if (word_we) begin
            mem[word_addr] <= word_wdata;
        end
        for (int l = 0; l < LANES; l++) begin
            if (byte_we[l] && !word_hits_byte) begin
                mem[byte_addr][l*BYTE_W +: BYTE_W] <= byte_wdata;
            end
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = mem[rd_addr[g]];
    end

endmodule

// File: rtl/lbt_host.sv
module lbt_host
    import lbt_pkg::*;
#(
    parameter int          DW      = 32,
    parameter logic [7:0]  SEL_TX  = 8'h1D,
    parameter logic [7:0]  SEL_RX  = 8'h1E,
    localparam int LANES  = DW / BYTE_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [7:0]        host_addr,
    input  logic [LANE_W-1:0] host_lane,
    input  logic              host_we,
    input  logic              busy,
    input  logic [DW-1:0]     tx_word,
    input  logic [DW-1:0]     rx_word,
    output logic [LANES-1:0]  tx_byte_we,
    output logic [LANES-1:0]  rx_byte_we,
    output logic [BYTE_W-1:0] host_rdata
);

    logic sel_tx;
    logic sel_rx;
    logic [BYTE_W-1:0] tx_lanes [LANES];
    logic [BYTE_W-1:0] rx_lanes [LANES];
    logic [LANES-1:0]  lane_hot;

    assign sel_tx = (host_addr == SEL_TX);
    assign sel_rx = (host_addr == SEL_RX);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tx_lanes[g] = tx_word[g*BYTE_W +: BYTE_W];
        assign rx_lanes[g] = rx_word[g*BYTE_W +: BYTE_W];
        assign lane_hot[g] = (host_lane == LANE_W'(g));
    end

    // receive memory belongs to the capture path while a run is active
    assign tx_byte_we = (host_we && sel_tx) ? lane_hot : '0;
    assign rx_byte_we = (host_we && sel_rx && !busy) ? lane_hot : '0;

    always_comb begin
        host_rdata = '0;
        if (sel_tx) begin
            host_rdata = tx_lanes[host_lane];
        end else if (sel_rx) begin
            host_rdata = rx_lanes[host_lane];
        end
    end

endmodule

// File: rtl/lbt_seq.sv
module lbt_seq
    import lbt_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int LAT_W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic [LAT_W-1:0] latency,
    output lbt_state_e       state_o,
    output logic [AW-1:0]    tx_ptr,
    output logic [AW-1:0]    cap_ptr,
    output logic             cap_we,
    output logic             tx_step,
    output logic             busy,
    output logic             done
);

    lbt_state_e       state_q;
    lbt_state_e       state_d;
    logic [LAT_W-1:0] lat_cnt;
    logic             lat_zero;
    logic             cap_last;
    logic             accept_start;
    logic             next_running;

    assign lat_zero     = (lat_cnt == '0);
    assign cap_last     = (cap_ptr == AW'(DEPTH - 1));
    assign accept_start = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && cmd_start;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (cmd_start) state_d = ST_LATENCY;
            end
            ST_LATENCY: begin
                if (cmd_stop)      state_d = ST_IDLE;
                else if (lat_zero) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (cmd_stop || cap_last) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_comb begin
        busy         = 1'b0;
        done         = 1'b0;
        cap_we       = 1'b0;
        next_running = (state_d == ST_LATENCY) || (state_d == ST_CAPTURE);
        unique case (state_q)
            ST_IDLE:    ;
            ST_LATENCY: busy = 1'b1;
            ST_CAPTURE: begin
                busy   = 1'b1;
                cap_we = !cmd_stop;
            end
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
        tx_step = busy && next_running;
    end

    assign state_o = state_q;

    // latency countdown and memory pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            tx_ptr  <= '0;
            cap_ptr <= '0;
        end else begin
            if (accept_start) begin
                lat_cnt <= latency;
            end else if (state_q == ST_LATENCY && !lat_zero) begin
                lat_cnt <= lat_cnt - 1'b1;
            end

            if (accept_start) begin
                tx_ptr <= '0;
            end else if (tx_step) begin
                tx_ptr <= (tx_ptr == AW'(DEPTH - 1)) ? '0 : tx_ptr + 1'b1;
            end

            if (accept_start) begin
                cap_ptr <= '0;
            end else if (cap_we && !cap_last) begin
                cap_ptr <= cap_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/iolink_tester.sv
module iolink_tester
    import lbt_pkg::*;
#(
    parameter int         DW     = 32,
    parameter int         DEPTH  = 512,
    parameter int         LAT_W  = 16,
    parameter logic [7:0] SEL_TX = 8'h1D,
    parameter logic [7:0] SEL_RX = 8'h1E,
    localparam int AW     = $clog2(DEPTH),
    localparam int LANES  = DW / BYTE_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        host_addr,
    input  logic [AW-1:0]     host_word,
    input  logic [LANE_W-1:0] host_lane,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              host_we,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [LAT_W-1:0]  latency,
    output logic [DW-1:0]     link_tx,
    input  logic [DW-1:0]     link_rx,
    output logic              busy,
    output logic              done
);

    lbt_state_e       seq_state;
    logic [AW-1:0]    tx_ptr;
    logic [AW-1:0]    cap_ptr;
    logic             cap_we;
    logic             tx_step;
    logic [LANES-1:0] tx_byte_we;
    logic [LANES-1:0] rx_byte_we;
    logic [AW-1:0]    tx_raddr [2];
    logic [DW-1:0]    tx_rdata [2];
    logic [AW-1:0]    rx_raddr [1];
    logic [DW-1:0]    rx_rdata [1];
    logic [DW-1:0]    link_tx_q;

    lbt_seq #(
        .DEPTH (DEPTH),
        .LAT_W (LAT_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .latency   (latency),
        .state_o   (seq_state),
        .tx_ptr    (tx_ptr),
        .cap_ptr   (cap_ptr),
        .cap_we    (cap_we),
        .tx_step   (tx_step),
        .busy      (busy),
        .done      (done)
    );

    lbt_host #(
        .DW     (DW),
        .SEL_TX (SEL_TX),
        .SEL_RX (SEL_RX)
    ) i_host (
        .host_addr  (host_addr),
        .host_lane  (host_lane),
        .host_we    (host_we),
        .busy       (busy),
        .tx_word    (tx_rdata[0]),
        .rx_word    (rx_rdata[0]),
        .tx_byte_we (tx_byte_we),
        .rx_byte_we (rx_byte_we),
        .host_rdata (host_rdata)
    );

    assign tx_raddr[0] = host_word;
    assign tx_raddr[1] = tx_ptr;
    assign rx_raddr[0] = host_word;

    lbt_ram #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .NRD   (2)
    ) i_tx_ram (
        .clk        (clk),
        .byte_we    (tx_byte_we),
        .byte_addr  (host_word),
        .byte_wdata (host_wdata),
        .word_we    (1'b0),
        .word_addr  ('0),
        .word_wdata ('0),
        .rd_addr    (tx_raddr),
        .rd_data    (tx_rdata)
    );

    lbt_ram #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .NRD   (1)
    ) i_rx_ram (
        .clk        (clk),
        .byte_we    (rx_byte_we),
        .byte_addr  (host_word),
        .byte_wdata (host_wdata),
        .word_we    (cap_we),
        .word_addr  (cap_ptr),
        .word_wdata (link_rx),
        .rd_addr    (rx_raddr),
        .rd_data    (rx_rdata)
    );

    // outgoing bus register: drives a transmit word only while a run continues
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_tx_q <= '0;
        end else if (tx_step) begin
            link_tx_q <= tx_rdata[1];
        end else begin
            link_tx_q <= '0;
        end
    end

    assign link_tx = link_tx_q;

endmodule

// File: rtl/iolink_tester_chk.sv
module iolink_tester_chk
    import lbt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 512,
    parameter int LAT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic             cmd_stop,
    input logic [LAT_W-1:0] latency,
    input logic             busy,
    input logic             done,
    input logic [DW-1:0]    link_tx,
    input lbt_state_e       seq_state
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic [LAT_W:0]   wait_cnt;
    logic [LAT_W-1:0] lat_ref;
    logic [CW-1:0]    cap_cnt;
    logic             start_ok;

    assign start_ok = ((seq_state == ST_IDLE) || (seq_state == ST_DONE)) && cmd_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            lat_ref  <= '0;
            cap_cnt  <= '0;
        end else begin
            if (start_ok) lat_ref <= latency;
            if (seq_state == ST_LATENCY) wait_cnt <= wait_cnt + 1'b1;
            else                         wait_cnt <= '0;
            if (start_ok) cap_cnt <= '0;
            else if (seq_state == ST_CAPTURE && !cmd_stop) cap_cnt <= cap_cnt + 1'b1;
        end
    end

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start) |=> (busy && !done));  // R4

    AST_LATENCY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_CAPTURE && $past(seq_state) == ST_LATENCY)
            |-> (wait_cnt == ({1'b0, lat_ref} + 1'b1)));  // R5

    AST_CAPTURE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        cap_cnt <= CW'(DEPTH));  // R7

    AST_COMPLETE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_DONE && $past(seq_state) == ST_CAPTURE && !$past(cmd_stop))
            |-> (cap_cnt == CW'(DEPTH)));  // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R8

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_CAPTURE && cmd_stop) |=> (!busy && done));  // R9

    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_LATENCY && cmd_stop) |=> (!busy && !done));  // R10

    AST_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (link_tx == '0));  // R11

endmodule

bind iolink_tester iolink_tester_chk #(
    .DW    (DW),
    .DEPTH (DEPTH),
    .LAT_W (LAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .latency   (latency),
    .busy      (busy),
    .done      (done),
    .link_tx   (link_tx),
    .seq_state (seq_state)
);

// File: tb/test_iolink_tester.sv
`timescale 1ns/1ps
module test_iolink_tester;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam logic [7:0] A_TX = 8'h1D;
    localparam logic [7:0] A_RX = 8'h1E;
    localparam int NVEC = 5;
    // {latency, loopback xor mask, expected busy length}
    localparam logic [63:0] VEC [NVEC] = '{
        {16'd0,   32'h0000_0000, 16'd513},
        {16'd1,   32'hFFFF_FFFF, 16'd514},
        {16'd7,   32'h0F0F_00FF, 16'd520},
        {16'd511, 32'h0000_0000, 16'd1024},
        {16'd700, 32'h1234_5678, 16'd1213}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [8:0]  host_word = '0;
    logic [1:0]  host_lane = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_we = 1'b0;
    logic [7:0]  host_rdata;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic [15:0] latency = '0;
    logic [31:0] link_tx;
    logic [31:0] link_rx;
    logic [31:0] rx_mask = '0;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] exp_rx [DEPTH];

    assign link_rx = link_tx ^ rx_mask;

    iolink_tester i_iolink_tester (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_word(host_word),
        .host_lane(host_lane), .host_wdata(host_wdata), .host_we(host_we),
        .host_rdata(host_rdata), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .latency(latency), .link_tx(link_tx), .link_rx(link_rx),
        .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] pat(input int i);
        return (32'(i + 1) * 32'h9E37_79B9) ^ (32'(i) << 20);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input int w, input int l, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_word = 9'(w); host_lane = 2'(l); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, input int w, output logic [31:0] v);
        host_we = 1'b0;
        host_addr = a; host_word = 9'(w);
        for (int l = 0; l < 4; l++) begin
            host_lane = 2'(l);
            #1;
            v[l*8 +: 8] = host_rdata;
        end
    endtask

    task automatic rx_compare(input string req);
        int bad = 0;
        logic [31:0] v;
        logic [31:0] first_a = '0;
        logic [31:0] first_e = '0;
        for (int j = 0; j < DEPTH; j++) begin
            host_rd(A_RX, j, v);
            if (v !== exp_rx[j]) begin
                if (bad == 0) begin first_a = v; first_e = exp_rx[j]; end
                bad++;
            end
        end
        check(req, {first_a, 32'(bad)}, {first_e, 32'd0});
    endtask

    // stop_at / restart_at / hw_at: negedge index c at which to drive; -1 = never
    task automatic run_seq(input int lat, input logic [31:0] mask, input int stop_at,
                           input int restart_at, input int hw_at, input string tag);
        int end_c, nwr, c, bad_tx;
        logic exp_done;
        if (stop_at >= 0 && stop_at + 1 <= lat + 1) begin
            end_c = stop_at + 1; nwr = 0; exp_done = 1'b0;
        end else if (stop_at >= 0 && stop_at + 1 <= lat + 513) begin
            end_c = stop_at + 1; nwr = stop_at - lat - 1; exp_done = 1'b1;
        end else begin
            end_c = lat + 513; nwr = DEPTH; exp_done = 1'b1;
        end
        rx_mask = mask;
        latency = 16'(lat);
        @(negedge clk);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check({tag, " R4 start busy/done"}, {busy, done}, {1'b1, 1'b0});
        c = 0; bad_tx = 0;
        while (busy && c < lat + 600) begin
            cmd_stop  = (c == stop_at);
            cmd_start = (c == restart_at);
            if (c == hw_at) begin
                host_addr = A_RX; host_word = 9'd7; host_lane = 2'd0;
                host_wdata = 8'hAB; host_we = 1'b1;
            end else begin
                host_we = 1'b0;
            end
            @(negedge clk);
            c++;
            if (busy && link_tx !== pat((c - 1) % DEPTH)) bad_tx++;
        end
        cmd_stop = 1'b0; cmd_start = 1'b0; host_we = 1'b0;
        check({tag, " R5 R8 busy length"}, 64'(c), 64'(end_c));
        check({tag, " R6 transmit stream"}, 64'(bad_tx), 64'd0);
        check({tag, " R11 link quiet"}, 64'(link_tx), 64'd0);
        check({tag, " R8 done flag"}, {busy, done}, {1'b0, exp_done});
        for (int j = 0; j < nwr; j++) exp_rx[j] = pat((lat + j) % DEPTH) ^ mask;
        rx_compare({tag, " R7 receive contents"});
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {busy, done, link_tx}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {busy, done, link_tx}, '0);

        for (int i = 0; i < DEPTH; i++)
            for (int l = 0; l < 4; l++) host_wr(A_TX, i, l, pat(i)[l*8 +: 8]);
        host_rd(A_TX, 0, v);   check("R2 tx word 0", 64'(v), 64'(pat(0)));
        host_rd(A_TX, 255, v); check("R2 tx word 255", 64'(v), 64'(pat(255)));
        host_rd(A_TX, 511, v); check("R2 tx word 511", 64'(v), 64'(pat(511)));
        host_rd(8'h20, 3, v);  check("R2 unmapped reads zero", 64'(v), 64'd0);

        host_wr(A_RX, 3, 0, 8'hA5); host_wr(A_RX, 3, 1, 8'h5A);
        host_wr(A_RX, 3, 2, 8'hC3); host_wr(A_RX, 3, 3, 8'h3C);
        host_rd(A_RX, 3, v);   check("R3 idle rx write", 64'(v), 64'h3CC3_5AA5);

        for (int k = 0; k < NVEC; k++) begin
            run_seq(int'(VEC[k][63:48]), VEC[k][47:16], -1, -1, -1, $sformatf("vec%0d", k));
            check($sformatf("vec%0d R8 table length", k), 64'(int'(VEC[k][63:48]) + 513),
                  64'(VEC[k][15:0]));
        end

        // R9: stop while capturing, 10 words written
        run_seq(3, 32'h0, 14, -1, -1, "stop_capture R9");

        // R10 abort in latency, R4 restart ignored, R3 host write ignored while busy
        run_seq(20, 32'h0, 10, 5, 8, "abort R10 R3");

        // start again from IDLE after abort, from DONE afterwards
        run_seq(2, 32'hAAAA_5555, -1, -1, -1, "rerun R4");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule